// File: doc/BRIEF.md
# Sequential Shift-Add Byte Multiplier

This block multiplies two unsigned bytes with a small datapath that a control state machine steps through a shift-and-add loop. It has no reset and no start strobe. It has a clock, one shared operand bus, a result byte, an overflow flag and a ready flag. While ready is high, the unit takes the multiplicand from the bus at the first rising edge and the multiplier at the second. It then runs one iteration per multiplier bit. Each iteration has two steps. A shift-right step moves the low multiplier bit into a carry flag. An accumulate step then adds the multiplicand into the upper half of the partial product when that flag is set, and shifts the partial product right.

When the loop ends, the low byte of the product goes to the result register. The overflow flag is set when any bit of the upper half is nonzero. Ready then rises again, so a new pair of operands can follow at once. The result and overflow flag stay unchanged until the next computation finishes.

Every register has a power-up value set by a parameter. Any state encoding, including the unused ones, and any value of the iteration counter lead back to the capture state in a bounded number of cycles.

Top module: `seqmul_top`

## Requirements
- R1: Ready is high for exactly two consecutive cycles. It is then low for exactly 2W+1 cycles (17 for W=8) before it rises again.
- R2: The bus is sampled only at the two rising edges that end the two ready-high cycles. Values driven on the bus at any other time do not affect the outcome.
- R3: When the product of the two captured operands is below 2^W, the result equals that product and the overflow flag is 0 in the first cycle of the next ready window.
- R4: When the product is 2^W or more, the overflow flag is 1 in the first cycle of the next ready window. The result value is then not specified.
- R5: The result and the overflow flag do not change from the first cycle of one ready window until the computation that starts in that window completes.
- R6: A state register holding any of the unused encodings 5, 6 or 7 (3-bit state; 0 and 1 are the two capture states, 2 shift, 3 accumulate, 4 finish) is in the first capture state after one clock edge, so ready is high after that edge.
- R7: Starting from any legal state with any iteration-counter value, ready rises within 2W+1 clock edges. From shift with count c, this takes 2(W-c)+1 edges. From accumulate with count c, it takes 2(W-1-c)+2 edges. From finish, it takes 1 edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| data_i | input | W | Shared operand bus: multiplicand, then multiplier |
| result_o | output | W | Low W bits of the last product |
| ovf_o | output | 1 | Last product did not fit in W bits |
| ready_o | output | 1 | High during the two operand-capture cycles |

## Verification
A new result and overflow flag are due in the first cycle in which ready is high again. That cycle comes 2W+1 low cycles after the second capture cycle. The bench drives the bus and samples the outputs on falling edges. It counts the low cycles and checks the outputs exactly in the cycle where ready rises. During the low cycles it drives random values on the bus and checks that the held outputs stay the same. A separate set of instances starts from chosen power-up states and counters. For each one, the bench counts the edges until ready first rises and compares that count with the number R6 or R7 gives.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

  // Controller states; encodings 5..7 are unused and recover to ST_TAKE_A
  typedef enum logic [2:0] {
    ST_TAKE_A  = 3'd0,
    ST_TAKE_B  = 3'd1,
    ST_SHIFT   = 3'd2,
    ST_ACCUM   = 3'd3,
    ST_FINISH  = 3'd4
  } mstate_e;

  // Datapath operation selected by the controller each cycle
  typedef enum logic [2:0] {
    DP_IDLE,
    DP_LOAD_A,
    DP_LOAD_B,
    DP_SHIFT,
    DP_ACCUM,
    DP_FINISH
  } dp_op_e;

endpackage

// File: rtl/seqmul_adder.sv
module seqmul_adder #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] addend,
  output logic [W:0]   sum
);

  always_comb begin
    if (en) sum = {1'b0, acc} + {1'b0, addend};
    else    sum = {1'b0, acc};
  end

endmodule

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
  import seqmul_pkg::*;
#(
  parameter logic [2:0] PWRUP_STATE = 3'd0
) (
  input  logic   clk,
  input  logic   cnt_last,
  output logic   ready,
  output dp_op_e op
);

  mstate_e state_q = mstate_e'(PWRUP_STATE);
  mstate_e state_d;

  always_comb begin
    state_d = ST_TAKE_A;
    op      = DP_IDLE;
    case (state_q)
      ST_TAKE_A: begin
        op      = DP_LOAD_A;
        state_d = ST_TAKE_B;
      end
      ST_TAKE_B: begin
        op      = DP_LOAD_B;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        op      = DP_SHIFT;
        state_d = ST_ACCUM;
      end
      ST_ACCUM: begin
        op      = DP_ACCUM;
        state_d = cnt_last ? ST_FINISH : ST_SHIFT;
      end
      ST_FINISH: begin
        op      = DP_FINISH;
        state_d = ST_TAKE_A;
      end
      default: begin
        op      = DP_IDLE;
        state_d = ST_TAKE_A;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

  assign ready = (state_q == ST_TAKE_A) || (state_q == ST_TAKE_B);

  // R6: unused encodings return to the first capture state in one edge
  a_r6_illegal_recover: assert property (@(posedge clk)
    (state_q > ST_FINISH) |=> (state_q == ST_TAKE_A));

  // R1: the two capture cycles are back to back, then the loop starts
  a_r1_capture_pair: assert property (@(posedge clk)
    (state_q == ST_TAKE_A) |=> (state_q == ST_TAKE_B));
  a_r1_capture_ends: assert property (@(posedge clk)
    (state_q == ST_TAKE_B) |=> (state_q == ST_SHIFT));

  // R7: the last accumulate always leads to finish
  a_r7_loop_exit: assert property (@(posedge clk)
    (state_q == ST_ACCUM && cnt_last) |=> (state_q == ST_FINISH));

endmodule

// File: rtl/seqmul_datapath.sv
module seqmul_datapath
  import seqmul_pkg::*;
#(
  parameter int          W           = 8,
  parameter int unsigned PWRUP_COUNT = 0
) (
  input  logic         clk,
  input  dp_op_e       op,
  input  logic [W-1:0] data_i,
  output logic         cnt_last,
  output logic [W-1:0] result,
  output logic         ovf
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_ITER = CW'(W - 1);

  logic [W-1:0]  mcand_q  = '0;
  logic [W-1:0]  mplier_q = '0;
  logic [W-1:0]  hi_q     = '0;
  logic [W-1:0]  lo_q     = '0;
  logic          carry_q  = 1'b0;
  logic [CW-1:0] cnt_q    = CW'(PWRUP_COUNT);
  logic [W-1:0]  res_q    = '0;
  logic          ovf_q    = 1'b0;
  logic [W:0]    sum;

  seqmul_adder #(.W(W)) u_adder (
    .en     (carry_q),
    .acc    (hi_q),
    .addend (mcand_q),
    .sum    (sum)
  );

  assign cnt_last = (cnt_q >= LAST_ITER);

  always_ff @(posedge clk) begin
    case (op)
      DP_LOAD_A: mcand_q <= data_i;
      DP_LOAD_B: begin
        mplier_q <= data_i;
        hi_q     <= '0;
        lo_q     <= '0;
        carry_q  <= 1'b0;
        cnt_q    <= '0;
      end
      DP_SHIFT: begin
        carry_q  <= mplier_q[0];
        mplier_q <= {1'b0, mplier_q[W-1:1]};
      end
      DP_ACCUM: begin
        hi_q  <= sum[W:1];
        lo_q  <= {sum[0], lo_q[W-1:1]};
        cnt_q <= cnt_q + 1'b1;
      end
      DP_FINISH: begin
        res_q <= lo_q;
        ovf_q <= |hi_q;
      end
      default: ;
    endcase
  end

  assign result = res_q;
  assign ovf    = ovf_q;

  // R7: loading the multiplier always restarts the iteration count
  a_r7_count_restart: assert property (@(posedge clk)
    (op == DP_LOAD_B) |=> (cnt_q == '0));

  // R3: an empty partial product with a zero carry stays empty through an accumulate
  a_r3_zero_accum: assert property (@(posedge clk)
    (op == DP_ACCUM && !carry_q && hi_q == '0) |=> (hi_q == '0));

endmodule

// File: rtl/seqmul_top.sv
module seqmul_top
  import seqmul_pkg::*;
#(
  parameter int          W           = 8,
  parameter logic [2:0]  PWRUP_STATE = 3'd0,
  parameter int unsigned PWRUP_COUNT = 0
) (
  input  logic         clk,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] result_o,
  output logic         ovf_o,
  output logic         ready_o
);

  dp_op_e op;
  logic   cnt_last;

  seqmul_ctrl #(.PWRUP_STATE(PWRUP_STATE)) u_ctrl (
    .clk      (clk),
    .cnt_last (cnt_last),
    .ready    (ready_o),
    .op       (op)
  );

  seqmul_datapath #(.W(W), .PWRUP_COUNT(PWRUP_COUNT)) u_dp (
    .clk      (clk),
    .op       (op),
    .data_i   (data_i),
    .cnt_last (cnt_last),
    .result   (result_o),
    .ovf      (ovf_o)
  );

  // R5: outputs hold still across the capture window
  a_r5_hold_in_capture: assert property (@(posedge clk)
    ready_o |=> ($stable(result_o) && $stable(ovf_o)));

endmodule

// File: tb/seqmul_top_tb.sv
module seqmul_top_tb;

  localparam int W      = 8;
  localparam int NREC   = 7;
  localparam int LOWLEN = 2 * W + 1;

  logic         clk = 1'b0;
  logic [W-1:0] bus = '0;
  logic [W-1:0] result_o;
  logic         ovf_o;
  logic         ready_o;
  logic [NREC-1:0] rec_ready;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit rec_done = 1'b0;

  always #5 clk = ~clk;

  seqmul_top #(.W(W)) u_dut (
    .clk(clk), .data_i(bus), .result_o(result_o), .ovf_o(ovf_o), .ready_o(ready_o)
  );

  // Power-up cases for R6 and R7: state, counter, expected edges until ready
  function automatic logic [2:0] rec_state(input int k);
    case (k)
      0: return 3'd5;
      1: return 3'd6;
      2: return 3'd7;
      3: return 3'd2;
      4: return 3'd3;
      5: return 3'd4;
      default: return 3'd2;
    endcase
  endfunction

  function automatic int rec_count(input int k);
    case (k)
      2: return 7;
      4: return 5;
      5: return 3;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int rec_expect(input int k);
    logic [2:0] s;
    int c;
    s = rec_state(k);
    c = rec_count(k);
    if (s > 3'd4 || s == 3'd4) return 1;
    if (s == 3'd2) return 2 * (W - c) + 1;
    return 2 * (W - 1 - c) + 2;
  endfunction

  for (genvar k = 0; k < NREC; k++) begin : g_rec
    logic [W-1:0] r_res;
    logic         r_ovf;
    seqmul_top #(.W(W), .PWRUP_STATE(rec_state(k)), .PWRUP_COUNT(rec_count(k))) u_rec (
      .clk(clk), .data_i('0), .result_o(r_res), .ovf_o(r_ovf), .ready_o(rec_ready[k])
    );
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // R6, R7: edges until ready first rises from each power-up case
  initial begin : rec_check
    int first [NREC];
    for (int k = 0; k < NREC; k++) first[k] = 0;
    for (int n = 1; n <= 3 * W; n++) begin
      @(negedge clk);
      for (int k = 0; k < NREC; k++)
        if (first[k] == 0 && rec_ready[k]) first[k] = n;
    end
    for (int k = 0; k < NREC; k++) begin
      if (rec_state(k) > 3'd4)
        chk(first[k] == rec_expect(k), "R6 illegal state recovery edges", first[k], rec_expect(k));
      else
        chk(first[k] == rec_expect(k), "R7 legal state recovery edges", first[k], rec_expect(k));
    end
    rec_done = 1'b1;
  end

  // Called at the negedge of the first ready cycle of a window
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] held_r;
    logic         held_v;
    int           low;
    bit           hold_ok;
    int           prod;
    held_r  = result_o;
    held_v  = ovf_o;
    hold_ok = 1'b1;
    bus = a;
    @(negedge clk);
    chk(ready_o == 1'b1, "R1 second ready cycle", ready_o, 1);
    bus = b;
    @(negedge clk);
    low = 0;
    while (!ready_o && low < 4 * W) begin
      low++;
      if (result_o != held_r || ovf_o != held_v) hold_ok = 1'b0;
      bus = W'($urandom);   // R2: ignored outside the capture edges
      @(negedge clk);
    end
    chk(low == LOWLEN, "R1 ready low cycles", low, LOWLEN);
    chk(hold_ok, "R5 outputs held during computation", hold_ok, 1);
    prod = int'(a) * int'(b);
    if (prod >= (1 << W)) begin
      chk(ovf_o == 1'b1, "R4 overflow flag", ovf_o, 1);
    end else begin
      chk(ovf_o == 1'b0, "R3 overflow clear", ovf_o, 0);
      chk(result_o == W'(prod), "R3/R2 product value", result_o, prod);
    end
  endtask

  initial begin : main
    logic [W-1:0] ca [13] = '{8'd0, 8'd0, 8'd255, 8'd1, 8'd255, 8'd255,
                              8'd16, 8'd15, 8'd17, 8'd1, 8'd2, 8'd128, 8'd16};
    logic [W-1:0] cb [13] = '{8'd0, 8'd255, 8'd0, 8'd255, 8'd1, 8'd255,
                              8'd16, 8'd17, 8'd15, 8'd1, 8'd128, 8'd2, 8'd15};
    // Power-up: capture state, outputs at their initial values
    @(negedge clk);
    chk(ready_o == 1'b1, "R1 power-up second capture cycle", ready_o, 1);
    chk(result_o == '0 && ovf_o == 1'b0, "R5 power-up outputs", result_o, 0);
    while (ready_o) @(negedge clk);
    while (!ready_o) @(negedge clk);
    for (int i = 0; i < 13; i++) run_op(ca[i], cb[i]);
    for (int i = 0; i < 256; i++) run_op(W'(i), W'(255 - i));
    for (int i = 0; i < 256; i++) run_op(W'(i), W'(i % 23));
    for (int i = 0; i < 200; i++) run_op(W'($urandom), W'($urandom));
    wait (rec_done);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule